// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block lets several processors, called users here, pass 32-bit messages to each other through a bank of small hardware queues. Every queue has one message register. A bus write to that register appends a message and a bus read removes the oldest one. Next to the message register sit a full flag and an occupancy count. A sender checks the full flag or waits for a not-full interrupt. A receiver checks the count or waits for a new-message interrupt.

Each user has its own interrupt status word, enable mask and interrupt line. In every status word, each queue owns two adjacent bits: a new-message event in the even bit and a not-full event in the odd bit. Status bits are sticky and are cleared by writing ones. The enable mask has one port that sets bits and another that clears them, so no read-modify-write is needed.

The bus is a single-cycle word-addressed register port. Read data appears on the cycle after the request. The number of queues (up to 16), the number of users (up to 16) and the queue depth are parameters.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset all queues are empty, all full flags read 0, every status word and enable mask reads 0, and every interrupt line is low.
- R2: A write to word address 0x010+m appends the write data to queue m. A read from that address returns the oldest stored message and removes it, so messages come out in the order they went in. The word at 0x030+m reads the current number of stored messages.
- R3: The word at 0x020+m reads 1 when queue m holds DEPTH messages and 0 otherwise. A write to a full queue is dropped and leaves its contents and count unchanged.
- R4: A read of an empty queue's message address returns 0 and leaves the count at 0.
- R5: Each accepted append to queue m sets bit 2m of the status word of every user.
- R6: A removal that takes queue m from full to not full sets bit 2m+1 of the status word of every user. A removal from a queue that was not full does not set that bit.
- R7: For user u, the status word is at 0x041+4u. Writing it clears every bit that is written as 1 and leaves every bit written as 0 unchanged. A status bit stays set after its cause has gone until it is cleared this way.
- R8: For user u, writing 0x042+4u ORs the write data into the enable mask, and writing 0x043+4u clears the mask bits that are written as 1. Reading either address returns the current mask, limited to 2*NUM_FIFOS bits.
- R9: The interrupt line of user u is high exactly when some bit is set in both that user's status word and its enable mask.
- R10: Word address 0x000 reads the REV_VALUE parameter. Reads of any address not described above return 0, and writes to such addresses change no state.
- R11: The data for a read request is on bus_rdata in the cycle after the request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
The bench fills every queue one entry past capacity. A design that let the extra write through would show a count above DEPTH or would corrupt the oldest entry. The bench then drains each queue and checks that the not-full event fires only on the removal from a full queue. A design that raised it on every removal would show that bit again after the bench cleared it. The bench reads empty queues, and a design whose read pointer still moved on those reads would return a later message out of order. The bench writes zeros to status words and sends writes to unmapped and out-of-range user and queue addresses. Afterwards it reads the state back to catch a wrong clear rule or a decode that aliases those addresses onto live registers.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

    localparam int unsigned MBX_AW = 10;
    localparam int unsigned MBX_DW = 32;
    localparam int unsigned MBX_IW = 4;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_REV,
        RG_MSG,
        RG_FULL,
        RG_CNT,
        RG_STAT,
        RG_ENSET,
        RG_ENCLR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [MBX_IW-1:0] idx;
    } reg_sel_t;

    // Word map: 0x000 revision, 0x01m/0x02m/0x03m queue m message/full/count,
    // 0x040 + 4u + {1,2,3} user u status/enable-set/enable-clear.
    function automatic reg_sel_t mbx_decode(input logic [MBX_AW-1:0] a,
                                            input int unsigned nf,
                                            input int unsigned nu);
        reg_sel_t s;
        s.kind = RG_NONE;
        s.idx  = a[3:0];
        if (a == '0) begin
            s.kind = RG_REV;
        end else if (a[9:6] == 4'd0) begin
            if (32'(a[3:0]) < nf) begin
                case (a[5:4])
                    2'd1:    s.kind = RG_MSG;
                    2'd2:    s.kind = RG_FULL;
                    2'd3:    s.kind = RG_CNT;
                    default: s.kind = RG_NONE;
                endcase
            end
        end else if (a[9:6] == 4'd1) begin
            s.idx = a[5:2];
            if (32'(a[5:2]) < nu) begin
                case (a[1:0])
                    2'd1:    s.kind = RG_STAT;
                    2'd2:    s.kind = RG_ENSET;
                    2'd3:    s.kind = RG_ENCLR;
                    default: s.kind = RG_NONE;
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/ipc_mbx_queue.sv
module ipc_mbx_queue #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/ipc_mbx_user.sv
module ipc_mbx_user #(
    parameter int unsigned EW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [EW-1:0] ev,
    input  logic          stat_wr,
    input  logic          en_set_wr,
    input  logic          en_clr_wr,
    input  logic [EW-1:0] wdata,
    output logic [EW-1:0] status,
    output logic [EW-1:0] enable,
    output logic          irq
);

    logic [EW-1:0] clr_mask;

    assign clr_mask = stat_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            // a new event wins over a clear in the same cycle
            status <= (status & ~clr_mask) | ev;
            if (en_set_wr)      enable <= enable | wdata;
            else if (en_clr_wr) enable <= enable & ~wdata;
        end
    end

    assign irq = |(status & enable);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter int unsigned NUM_FIFOS = 4,
    parameter int unsigned NUM_USERS = 2,
    parameter int unsigned DEPTH     = 4,
    parameter logic [31:0] REV_VALUE = 32'h0001_0200
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [9:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_USERS-1:0] irq
);

    localparam int unsigned EW = 2 * NUM_FIFOS;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    reg_sel_t      sel;
    logic [EW-1:0] ev;
    logic [31:0]   rd_next;

    logic [31:0]          q_head [NUM_FIFOS];
    logic [CW-1:0]        q_cnt  [NUM_FIFOS];
    logic [NUM_FIFOS-1:0] q_full, q_empty;
    logic [EW-1:0]        u_stat [NUM_USERS];
    logic [EW-1:0]        u_en   [NUM_USERS];

    assign sel = mbx_decode(bus_addr, NUM_FIFOS, NUM_USERS);

    for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_q
        logic hit, push, pop;
        assign hit  = bus_en && (sel.kind == RG_MSG) && (sel.idx == MBX_IW'(g));
        assign push = hit && bus_we;
        assign pop  = hit && !bus_we;

        ipc_mbx_queue #(.DW(32), .DEPTH(DEPTH)) q_i (
            .clk       (clk),
            .rst       (rst),
            .push      (push),
            .push_data (bus_wdata),
            .pop       (pop),
            .head      (q_head[g]),
            .cnt       (q_cnt[g]),
            .full      (q_full[g]),
            .empty     (q_empty[g])
        );

        assign ev[2*g]   = push && !q_full[g];
        assign ev[2*g+1] = pop && q_full[g];
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
        logic sel_u;
        assign sel_u = bus_en && bus_we && (sel.idx == MBX_IW'(u));

        ipc_mbx_user #(.EW(EW)) u_i (
            .clk       (clk),
            .rst       (rst),
            .ev        (ev),
            .stat_wr   (sel_u && (sel.kind == RG_STAT)),
            .en_set_wr (sel_u && (sel.kind == RG_ENSET)),
            .en_clr_wr (sel_u && (sel.kind == RG_ENCLR)),
            .wdata     (bus_wdata[EW-1:0]),
            .status    (u_stat[u]),
            .enable    (u_en[u]),
            .irq       (irq[u])
        );
    end

    always_comb begin
        rd_next = '0;
        case (sel.kind)
            RG_REV: rd_next = REV_VALUE;
            RG_MSG: begin
                for (int i = 0; i < NUM_FIFOS; i++)
                    if (sel.idx == MBX_IW'(i) && !q_empty[i]) rd_next = q_head[i];
            end
            RG_FULL: begin
                for (int i = 0; i < NUM_FIFOS; i++)
                    if (sel.idx == MBX_IW'(i)) rd_next = 32'(q_full[i]);
            end
            RG_CNT: begin
                for (int i = 0; i < NUM_FIFOS; i++)
                    if (sel.idx == MBX_IW'(i)) rd_next = 32'(q_cnt[i]);
            end
            RG_STAT: begin
                for (int i = 0; i < NUM_USERS; i++)
                    if (sel.idx == MBX_IW'(i)) rd_next = 32'(u_stat[i]);
            end
            RG_ENSET, RG_ENCLR: begin
                for (int i = 0; i < NUM_USERS; i++)
                    if (sel.idx == MBX_IW'(i)) rd_next = 32'(u_en[i]);
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_next;
    end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mbx_pkg::*;
#(
    parameter int unsigned NUM_FIFOS = 4,
    parameter int unsigned NUM_USERS = 2,
    parameter int unsigned DEPTH     = 4,
    localparam int unsigned EW = 2 * NUM_FIFOS,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_en,
    input logic                 bus_we,
    input logic [9:0]           bus_addr,
    input logic [EW-1:0]        chk_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_USERS-1:0] irq,
    input logic [CW-1:0]        q_cnt  [NUM_FIFOS],
    input logic [NUM_FIFOS-1:0] q_full,
    input logic [NUM_FIFOS-1:0] q_empty,
    input logic [EW-1:0]        u_stat [NUM_USERS],
    input logic [EW-1:0]        u_en   [NUM_USERS]
);

    reg_sel_t s;
    assign s = mbx_decode(bus_addr, NUM_FIFOS, NUM_USERS);

    for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_qc
        logic wr_q, rd_q;
        assign wr_q = bus_en && bus_we && s.kind == RG_MSG && s.idx == MBX_IW'(g);
        assign rd_q = bus_en && !bus_we && s.kind == RG_MSG && s.idx == MBX_IW'(g);

        // R3
        cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
            q_cnt[g] <= CW'(DEPTH));

        // R3
        full_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_q && q_full[g]) |=> $stable(q_cnt[g]));

        // R4
        empty_read_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_q && q_empty[g]) |=> (bus_rdata == '0 && q_cnt[g] == '0));

        for (genvar u = 0; u < NUM_USERS; u++) begin : g_uc
            // R5
            newmsg_all_users_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_q && !q_full[g]) |=> u_stat[u][2*g]);

            // R6
            notfull_event_chk: assert property (@(posedge clk) disable iff (rst)
                (rd_q && q_full[g]) |=> u_stat[u][2*g+1]);
        end
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_ec
        logic clr_wr;
        assign clr_wr = bus_en && bus_we && s.kind == RG_ENCLR && s.idx == MBX_IW'(u);

        // R8
        enclr_effect_chk: assert property (@(posedge clk) disable iff (rst)
            clr_wr |=> ((u_en[u] & $past(chk_wdata)) == '0));

        // R9
        irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
            (u_en[u] == '0) |-> !irq[u]);

        // R1
        reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (u_stat[u] == '0 && u_en[u] == '0 && !irq[u]));
    end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .NUM_FIFOS (NUM_FIFOS),
    .NUM_USERS (NUM_USERS),
    .DEPTH     (DEPTH)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .chk_wdata (bus_wdata[2*NUM_FIFOS-1:0]),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .q_cnt     (q_cnt),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .u_stat    (u_stat),
    .u_en      (u_en)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb_top;

    localparam int NF  = 4;
    localparam int NU  = 2;
    localparam int DP  = 4;
    localparam int EW  = 2 * NF;
    localparam logic [31:0] REV = 32'h0001_0200;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_en, bus_we;
    logic [9:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NU-1:0] irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ipc_mailbox #(.NUM_FIFOS(NF), .NUM_USERS(NU), .DEPTH(DP), .REV_VALUE(REV)) dut_i (
        .clk, .rst, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .irq
    );

    function automatic logic [9:0] a_msg(int m);   return 10'(16 + m); endfunction
    function automatic logic [9:0] a_full(int m);  return 10'(32 + m); endfunction
    function automatic logic [9:0] a_cnt(int m);   return 10'(48 + m); endfunction
    function automatic logic [9:0] a_stat(int u);  return 10'(65 + 4*u); endfunction
    function automatic logic [9:0] a_enset(int u); return 10'(66 + 4*u); endfunction
    function automatic logic [9:0] a_enclr(int u); return 10'(67 + 4*u); endfunction
    function automatic logic [31:0] pat(int m, int k);
        return 32'hA500_0000 | 32'(m << 12) | 32'(k * 3 + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int m = 0; m < NF; m++) begin
            rd(a_cnt(m), v);  chk("R1 count", v, 0);
            rd(a_full(m), v); chk("R1 full", v, 0);
        end
        for (int u = 0; u < NU; u++) begin
            rd(a_stat(u), v);  chk("R1 status", v, 0);
            rd(a_enset(u), v); chk("R1 enable", v, 0);
        end
        chk("R1 irq", 32'(irq), 0);

        // R10, R11 revision and unmapped space
        rd(10'h000, v); chk("R10 R11 revision", v, REV);
        rd(10'h001, v); chk("R10 unmapped 0x001", v, 0);
        rd(10'(16 + NF), v); chk("R10 queue index out of range", v, 0);
        rd(10'h040, v); chk("R10 unmapped 0x040", v, 0);
        rd(a_stat(NU), v); chk("R10 user index out of range", v, 0);
        rd(10'h3FF, v); chk("R10 unmapped 0x3FF", v, 0);
        wr(10'(16 + NF), 32'h1234_5678);
        wr(10'h040, 32'hFFFF_FFFF);
        wr(a_enset(NU), 32'hFFFF_FFFF);
        wr(a_stat(NU), 32'hFFFF_FFFF);
        for (int m = 0; m < NF; m++) begin
            rd(a_cnt(m), v); chk("R10 unmapped write left count", v, 0);
        end
        for (int u = 0; u < NU; u++) begin
            rd(a_enset(u), v); chk("R10 unmapped write left enable", v, 0);
            rd(a_stat(u), v);  chk("R10 unmapped write left status", v, 0);
        end

        // Per-queue sweep: R2 R3 R4 R5 R6 R7
        for (int m = 0; m < NF; m++) begin
            rd(a_msg(m), v); chk("R4 empty read data", v, 0);
            rd(a_cnt(m), v); chk("R4 empty read count", v, 0);
            for (int k = 0; k <= DP; k++) begin
                wr(a_msg(m), pat(m, k));
                rd(a_cnt(m), v);
                chk("R2 R3 count after append", v, 32'((k < DP) ? k + 1 : DP));
            end
            rd(a_full(m), v); chk("R3 full flag set", v, 1);
            for (int u = 0; u < NU; u++) begin
                rd(a_stat(u), v); chk("R5 new-message bit", v, 32'(1) << (2*m));
            end
            rd(a_msg(m), v);  chk("R2 oldest first", v, pat(m, 0));
            rd(a_full(m), v); chk("R3 full flag cleared", v, 0);
            for (int u = 0; u < NU; u++) begin
                rd(a_stat(u), v);
                chk("R6 not-full bit", v, (32'(1) << (2*m)) | (32'(1) << (2*m+1)));
            end
            wr(a_stat(0), 32'(1) << (2*m+1));
            for (int k = 1; k < DP; k++) begin
                rd(a_msg(m), v); chk("R2 order", v, pat(m, k));
            end
            rd(a_stat(0), v); chk("R6 no event from non-full pop", v, 32'(1) << (2*m));
            rd(a_cnt(m), v);  chk("R2 count drained", v, 0);
            rd(a_msg(m), v);  chk("R4 empty after drain", v, 0);
            rd(a_cnt(m), v);  chk("R4 count stays zero", v, 0);
            wr(a_stat(1), 32'h0);
            rd(a_stat(1), v);
            chk("R7 zero write keeps sticky bits", v, (32'(1) << (2*m)) | (32'(1) << (2*m+1)));
            wr(a_stat(1), 32'(1) << (2*m));
            rd(a_stat(1), v); chk("R7 one clears only its bit", v, 32'(1) << (2*m+1));
            wr(a_stat(0), 32'hFFFF_FFFF);
            wr(a_stat(1), 32'hFFFF_FFFF);
            rd(a_stat(0), v); chk("R7 full clear", v, 0);
        end

        // R8 enable set/clear
        wr(a_enset(0), 32'h5);
        rd(a_enset(0), v); chk("R8 set read", v, 32'h5);
        rd(a_enclr(0), v); chk("R8 clear-address read", v, 32'h5);
        wr(a_enset(0), 32'h2);
        rd(a_enset(0), v); chk("R8 set ORs", v, 32'h7);
        wr(a_enclr(0), 32'h1);
        rd(a_enset(0), v); chk("R8 clear", v, 32'h6);
        rd(a_enset(1), v); chk("R8 other user untouched", v, 0);
        wr(a_enset(0), 32'hFFFF_FFFF);
        rd(a_enclr(0), v); chk("R8 mask width", v, (32'(1) << EW) - 1);
        wr(a_enclr(0), 32'hFFFF_FFFF);
        rd(a_enset(0), v); chk("R8 clear all", v, 0);

        // R9 interrupt lines, R7 stickiness
        wr(a_enset(1), 32'h4);
        wr(a_msg(0), 32'h11);
        chk("R9 disabled event no irq", 32'(irq), 0);
        wr(a_msg(1), 32'h22);
        chk("R9 enabled event raises irq", 32'(irq), 32'b10);
        rd(a_msg(1), v); chk("R2 queue 1 data", v, 32'h22);
        chk("R7 R9 irq holds after drain", 32'(irq), 32'b10);
        wr(a_stat(1), 32'h4);
        chk("R9 irq drops after clear", 32'(irq), 0);
        rd(a_msg(0), v); chk("R2 queue 0 data", v, 32'h11);
        wr(a_enset(0), 32'h1);
        chk("R9 late enable of pending bit", 32'(irq), 32'b01);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule